// File: doc/BRIEF.md
# SPI Receive Path with Overflow and Mode-Fault Flags

This block takes serial data from an SPI link into a one-byte receive holding register. It reports three conditions to software: a byte is waiting (receive-full), a byte was lost because the previous one was still unread (overflow), and the slave-select line disagrees with the selected master or slave role (mode fault). Software sees a small register interface. It has one control write port, a status value with a read strobe, and a data value with a read strobe. The flags clear only when these accesses come in a fixed order.

The serial clock and slave-select are sampled in the system clock domain. A bit counter tracks the position inside the byte. When the first bit of a new byte is captured while the holding register is still full, overflow is raised and that whole byte is dropped, so the older byte stays readable. Two interrupt outputs are provided: a receive request and a combined error request. Overflow and mode fault share one enable for the error request.

Top module: `spi_rx_err`

## Requirements
- R1: In slave mode with `ss_n` low, eight captured bits form one byte, most significant bit first. The byte is loaded into `rx_data_o` and receive-full (`stat_o[0]`) is set, provided receive-full and overflow were both clear when its first bit was captured.
- R2: `ctrl_wdata[1]` selects the capture edge of `sck`: 0 captures on the rising edge, 1 captures on the falling edge.
- R3: If receive-full is set when the first bit of a byte is captured, overflow (`stat_o[1]`) is set, the byte is discarded, and `rx_data_o` keeps the older byte.
- R4: Receive-full clears only on a data read (`data_rd`) that follows a status read (`stat_rd`) that saw it set. A data read alone leaves it set.
- R5: Overflow clears only on a data read that follows a status read that saw overflow set. If overflow becomes set between the status read and the data read, it stays set and shows on the next status read.
- R6: While overflow is set, completed bytes neither set receive-full nor change `rx_data_o`.
- R7: In slave mode (`ctrl_wdata[0]`=0), `ss_n` rising partway through a byte sets mode fault (`stat_o[2]`). `ss_n` high also resets the bit counter, so the next byte is assembled from bit 0.
- R8: In master mode (`ctrl_wdata[0]`=1), a falling edge on `ss_n` sets mode fault.
- R9: Mode fault is never set while mode-fault enable (`ctrl_wdata[2]`) is 0.
- R10: Mode fault clears only on a control write (`ctrl_wr`) that follows a status read that saw it set. A control write alone leaves it set.
- R11: `rx_irq` is high exactly when receive-full is set and the receive interrupt enable (`ctrl_wdata[3]`) is 1.
- R12: `err_irq` is high exactly when overflow or mode fault is set and the error interrupt enable (`ctrl_wdata[4]`) is 1. The one enable covers both sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| mosi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select, active low |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 5 | Control value: [0] master, [1] falling-edge capture, [2] mode-fault enable, [3] receive irq enable, [4] error irq enable |
| stat_o | output | 3 | Status: [0] receive-full, [1] overflow, [2] mode fault |
| rx_data_o | output | DATA_W | Receive holding register |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Combined error interrupt request |

## Verification
The following are checked on every cycle:
- the holding register stays frozen while overflow persists;
- receive-full never rises while overflow is set;
- each flag falls only right after its own clearing access;
- mode fault never rises while its enable is low;
- each interrupt implies its enable and its source flag.

The bench scenarios must show what depends on the order of events: the bit order and edge choice in the assembled byte, overflow raised between the status read and the data read, the data value kept through a dropped byte, and mode fault from an aborted byte or from a master-mode select edge.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    localparam int STAT_W  = 3;
    localparam int CTRL_W  = 5;
    localparam int ST_RXF  = 0;
    localparam int ST_OVR  = 1;
    localparam int ST_MODF = 2;

    typedef struct packed {
        logic err_ie;
        logic rx_ie;
        logic modf_en;
        logic fall_edge;
        logic master;
    } ctrl_t;
endpackage

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic              sck,
    input  logic              mosi,
    input  logic              ss_n,
    output logic              first_bit,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_o,
    output logic              ss_abort,
    output logic              ss_fall_m
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              sck;
        logic              ss;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      edge_hit;
    logic      cap;

    always_comb begin
        st_d     = st_q;
        edge_hit = ctrl.fall_edge ? (!sck && st_q.sck) : (sck && !st_q.sck);
        cap      = edge_hit && (ctrl.master || !ss_n);
        st_d.sck = sck;
        st_d.ss  = ss_n;
        if (cap) begin
            st_d.sh  = {st_q.sh[DATA_W-2:0], mosi};
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + CNT_W'(1);
        end
        if (!ctrl.master && ss_n) begin
            st_d.cnt = '0;
        end
        first_bit = cap && (st_q.cnt == '0);
        byte_done = cap && (st_q.cnt == LAST);
        byte_o    = {st_q.sh[DATA_W-2:0], mosi};
        ss_abort  = !ctrl.master && ss_n && !st_q.ss && (st_q.cnt != '0);
        ss_fall_m = ctrl.master && !ss_n && st_q.ss;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ss  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first_bit,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              ss_abort,
    input  logic              ss_fall_m,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              ctrl_wr,
    input  ctrl_t             ctrl_wdata,
    output ctrl_t             ctrl_o,
    output logic [STAT_W-1:0] stat_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic              rxf;
        logic              ovr;
        logic              modf;
        logic              discard;
        logic              arm_rxf;
        logic              arm_ovr;
        logic              arm_modf;
        logic [DATA_W-1:0] data;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ctrl = ctrl_wdata;
            if (st_q.arm_modf) st_d.modf = 1'b0;
            st_d.arm_modf = 1'b0;
        end
        if (stat_rd) begin
            st_d.arm_rxf  = st_q.rxf;
            st_d.arm_ovr  = st_q.ovr;
            st_d.arm_modf = st_q.modf;
        end
        if (data_rd) begin
            if (st_q.arm_rxf) st_d.rxf = 1'b0;
            if (st_q.arm_ovr) st_d.ovr = 1'b0;
            st_d.arm_rxf = 1'b0;
            st_d.arm_ovr = 1'b0;
        end
        // overflow is decided when the first bit of the next byte lands
        if (first_bit) begin
            st_d.discard = st_q.rxf;
            if (st_q.rxf) st_d.ovr = 1'b1;
        end
        if (byte_done) begin
            if (!st_q.ovr && !st_q.discard) begin
                st_d.data = byte_in;
                st_d.rxf  = 1'b1;
            end
            st_d.discard = 1'b0;
        end
        if ((ss_abort || ss_fall_m) && st_q.ctrl.modf_en) begin
            st_d.modf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign data_o = st_q.data;
    always_comb begin
        stat_o          = '0;
        stat_o[ST_RXF]  = st_q.rxf;
        stat_o[ST_OVR]  = st_q.ovr;
        stat_o[ST_MODF] = st_q.modf;
    end
endmodule

// File: rtl/spi_rx_err.sv
module spi_rx_err
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              ss_n,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [STAT_W-1:0] stat_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_irq,
    output logic              err_irq
);
    ctrl_t             ctrl_q;
    logic              first_bit;
    logic              byte_done;
    logic [DATA_W-1:0] byte_w;
    logic              ss_abort;
    logic              ss_fall_m;

    spi_rx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl_q),
        .sck       (sck),
        .mosi      (mosi),
        .ss_n      (ss_n),
        .first_bit (first_bit),
        .byte_done (byte_done),
        .byte_o    (byte_w),
        .ss_abort  (ss_abort),
        .ss_fall_m (ss_fall_m)
    );

    spi_rx_status #(.DATA_W(DATA_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_bit  (first_bit),
        .byte_done  (byte_done),
        .byte_in    (byte_w),
        .ss_abort   (ss_abort),
        .ss_fall_m  (ss_fall_m),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_t'(ctrl_wdata)),
        .ctrl_o     (ctrl_q),
        .stat_o     (stat_o),
        .data_o     (rx_data_o)
    );

    assign rx_irq  = stat_o[ST_RXF] && ctrl_q.rx_ie;
    assign err_irq = (stat_o[ST_OVR] || stat_o[ST_MODF]) && ctrl_q.err_ie;
endmodule

// File: rtl/spi_rx_err_chk.sv
module spi_rx_err_chk
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input ctrl_t             ctrl,
    input logic [STAT_W-1:0] stat,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_irq,
    input logic              err_irq,
    input logic              data_rd,
    input logic              ctrl_wr
);
    assert_keep_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[ST_OVR] && $past(stat[ST_OVR])) |-> $stable(rx_data));

    assert_rxf_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[ST_RXF]) |-> $past(data_rd));

    assert_ovr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[ST_OVR]) |-> $past(data_rd));

    assert_no_rxf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_RXF]) |-> !$past(stat[ST_OVR]));

    assert_modf_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_MODF]) |-> $past(ctrl.modf_en));

    assert_modf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[ST_MODF]) |-> $past(ctrl_wr));

    assert_rx_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (ctrl.rx_ie && stat[ST_RXF]));

    assert_err_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (ctrl.err_ie && (stat[ST_OVR] || stat[ST_MODF])));
endmodule

bind spi_rx_err spi_rx_err_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl_q),
    .stat    (stat_o),
    .rx_data (rx_data_o),
    .rx_irq  (rx_irq),
    .err_irq (err_irq),
    .data_rd (data_rd),
    .ctrl_wr (ctrl_wr)
);

// File: tb/tb_spi_rx_err.sv
module tb_spi_rx_err;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       ss_n = 1'b1;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic [2:0] stat_o;
    logic [7:0] rx_data_o;
    logic       rx_irq;
    logic       err_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    spi_rx_err #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .stat_rd(stat_rd), .data_rd(data_rd), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .stat_o(stat_o), .rx_data_o(rx_data_o),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic [4:0] ctrl;
        logic [7:0] tx;
        logic       clr;
        logic [2:0] es;
        logic [7:0] ed;
        logic [2:0] ea;
    } vec_t;

    // falling-edge vector expects the inverted byte: the send task flips mosi between edges
    localparam vec_t VECS [5] = '{
        '{5'b01000, 8'hA5, 1'b1, 3'b001, 8'hA5, 3'b000},
        '{5'b01100, 8'h3C, 1'b1, 3'b001, 8'h3C, 3'b000},
        '{5'b01110, 8'hC3, 1'b1, 3'b001, 8'h3C, 3'b000},
        '{5'b01100, 8'h81, 1'b0, 3'b001, 8'h81, 3'b001},
        '{5'b01100, 8'h7E, 1'b1, 3'b011, 8'h81, 3'b000}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_stat();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic pulse_data();
        @(negedge clk) data_rd = 1'b1;
        @(negedge clk) data_rd = 1'b0;
    endtask

    task automatic write_ctrl(input logic [4:0] v);
        @(negedge clk) begin ctrl_wr = 1'b1; ctrl_wdata = v; end
        @(negedge clk) ctrl_wr = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) begin mosi = b[7-i]; sck = 1'b1; end
            idle(1);
            @(negedge clk) begin mosi = ~b[7-i]; sck = 1'b0; end
            idle(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk) ss_n = 1'b0;
        send_bits(b, 8);
        @(negedge clk) ss_n = 1'b1;
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R1 reset stat", {5'b0, stat_o}, 8'h00);
        check("R1 reset data", rx_data_o, 8'h00);
        check("R11 reset rx_irq", {7'b0, rx_irq}, 8'h00);
        check("R12 reset err_irq", {7'b0, err_irq}, 8'h00);

        // table walk: R1 byte assembly, R2 edge select, R3 overflow keeps old byte
        for (int v = 0; v < 5; v++) begin
            write_ctrl(VECS[v].ctrl);
            send_byte(VECS[v].tx);
            check("R1/R3 table stat", {5'b0, stat_o}, {5'b0, VECS[v].es});
            check("R1/R2/R3 table data", rx_data_o, VECS[v].ed);
            check("R11 table rx_irq", {7'b0, rx_irq}, {7'b0, VECS[v].es[0] & VECS[v].ctrl[3]});
            if (VECS[v].clr) begin
                pulse_stat();
                pulse_data();
            end
            idle(1);
            check("R4/R5 table after clear", {5'b0, stat_o}, {5'b0, VECS[v].ea});
        end

        // R4: a data read alone does not clear receive-full
        send_byte(8'h5A);
        pulse_data();
        check("R4 data read alone", {5'b0, stat_o}, 8'h01);
        pulse_stat();
        pulse_data();
        check("R4 ordered clear", {5'b0, stat_o}, 8'h00);

        // R5: overflow raised between status read and data read survives
        send_byte(8'hB1);
        pulse_stat();
        send_byte(8'h22);
        check("R3 overflow stat", {5'b0, stat_o}, 8'h03);
        check("R3 old byte kept", rx_data_o, 8'hB1);
        pulse_data();
        check("R5 overflow survives", {5'b0, stat_o}, 8'h02);

        // R6: no receive-full events while overflow set
        send_byte(8'h44);
        check("R6 no rxf", {5'b0, stat_o}, 8'h02);
        check("R6 data frozen", rx_data_o, 8'hB1);
        check("R6 no rx_irq", {7'b0, rx_irq}, 8'h00);

        write_ctrl(5'b11100);
        check("R12 err_irq on overflow", {7'b0, err_irq}, 8'h01);
        pulse_stat();
        pulse_data();
        check("R5 overflow cleared", {5'b0, stat_o}, 8'h00);
        check("R12 err_irq off", {7'b0, err_irq}, 8'h00);

        send_byte(8'h66);
        check("R6 reception resumes", rx_data_o, 8'h66);
        check("R11 rx_irq on", {7'b0, rx_irq}, 8'h01);
        write_ctrl(5'b00100);
        check("R11 rx_irq masked", {7'b0, rx_irq}, 8'h00);
        pulse_stat();
        pulse_data();

        // R7: slave abort mid-byte
        write_ctrl(5'b10100);
        @(negedge clk) ss_n = 1'b0;
        send_bits(8'hF0, 3);
        @(negedge clk) ss_n = 1'b1;
        idle(2);
        check("R7 slave mode fault", {5'b0, stat_o}, 8'h04);
        check("R12 err_irq on modf", {7'b0, err_irq}, 8'h01);
        write_ctrl(5'b10100);
        check("R10 write alone keeps modf", {5'b0, stat_o}, 8'h04);
        pulse_stat();
        write_ctrl(5'b10100);
        check("R10 ordered clear", {5'b0, stat_o}, 8'h00);
        send_byte(8'h96);
        check("R7 counter restarted", rx_data_o, 8'h96);
        pulse_stat();
        pulse_data();

        // R9: abort with mode-fault enable low
        write_ctrl(5'b10000);
        @(negedge clk) ss_n = 1'b0;
        send_bits(8'h0F, 3);
        @(negedge clk) ss_n = 1'b1;
        idle(2);
        check("R9 no modf when disabled", {5'b0, stat_o}, 8'h00);
        check("R9 no err_irq", {7'b0, err_irq}, 8'h00);

        // R8: master mode select driven low
        write_ctrl(5'b10101);
        @(negedge clk) ss_n = 1'b0;
        idle(2);
        check("R8 master mode fault", {5'b0, stat_o}, 8'h04);
        @(negedge clk) ss_n = 1'b1;
        pulse_stat();
        write_ctrl(5'b10001);
        check("R10 master clear", {5'b0, stat_o}, 8'h00);
        @(negedge clk) ss_n = 1'b0;
        idle(2);
        check("R9 master disabled", {5'b0, stat_o}, 8'h00);
        @(negedge clk) ss_n = 1'b1;
        idle(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule